// File: doc/BRIEF.md
# Coprocessor Interface Protocol Checker

This block sits on the slave side of a coprocessor's register port. A host processor reads and writes a small set of interface registers through a synchronous port made of chip select, read/write, a 5-bit word index, write data, read data and acknowledge. The block follows the protocol phase of the coprocessor. In the idle phase it waits for a command or condition access. In the transfer phase a command has started and the block waits for its operand transfers. Each access is judged legal or illegal against that phase. Every access is acknowledged, legal or not.

An illegal access does not stall or refuse the bus. It raises a pending violation. The next read of the response register returns a violation code in place of the normal response. Two cases hold the violation back until the next command or condition access starts a new instruction: a violation found while a state save or restore is in progress, and an illegal access that arrives once a save or restore is open. A small stub planner takes the operand count of each command from its write data. The coprocessor's arithmetic and its saved-state format are outside this block.

Register word indices: response 0, control 1, save 2, restore 3, operation word 4, command 5, condition 7, operand 8, register select 9, instruction address 10, operand address 11. The operation word, operand, register select and the two address registers form the in-operation group. Any other index is unmapped and has no effect.

Top module: `cpg_proto_guard`

## Requirements
- R1: `ack` rises one clock after `cs` is first sampled high and stays high while `cs` stays high. It falls one clock after `cs` is sampled low. One assertion of `cs`, however long, counts as a single access, and every access is acknowledged whether it is legal or not.
- R2: In the idle phase a response read returns 16'h8000. Read data is loaded when an access is taken and is held until the next access. Every access other than a response read loads 16'h0000.
- R3: A command write (index 5) whose `wdata[2:0]` is N > 0 enters the transfer phase. While M operands remain, a response read returns 16'h4000 | M. Each operand access (index 8, read or write) decrements M, and the block returns to idle when M reaches 0. A command with N = 0 stays idle.
- R4: An in-operation group access in the idle phase sets a violation. The next response read returns 16'h2F00 and clears it, so the read after that returns the normal response.
- R5: During the transfer phase, accesses to the operation word, register select and address registers are legal and leave the remaining count unchanged.
- R6: Save reads, restore writes, response reads and control writes without the abort bit never create a violation, in either phase.
- R7: After a save read or restore write, a violation is held back and response reads stay normal. The next command or condition access makes the violation visible and does not start the command. The next response read then returns 16'h2F00.
- R8: A command or condition access during the transfer phase is a violation. It abandons the transfer, and the block returns to idle.
- R9: A control write (index 1) with `wdata[1]` set clears visible and held-back violations, closes any open save or restore, and returns the block to idle.
- R10: A condition access (index 7) in idle, and any access to an unmapped index, leaves the phase unchanged and raises no violation.
- R11: During reset `ack` is low and `rdata` is 0. After reset the block is idle with no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register port |
| rw | input | 1 | 1 = read, 0 = write |
| reg_idx | input | 5 | Interface register word index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, held from acceptance of the access |
| ack | output | 1 | Bus acknowledge |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 3-bit operand count and the abort flag on bit 1. With these values it can run commands that need zero operands, a few operands, and the full seven. That covers the count boundaries at both ends and the last-operand return to idle. Holding chip select across several clocks checks that a long bus cycle is one access. The deferral cases use both save reads and restore writes, each followed by a command access or by an abort.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IX_RESP = 5'd0;
  localparam logic [IDX_W-1:0] IX_CTRL = 5'd1;
  localparam logic [IDX_W-1:0] IX_SAVE = 5'd2;
  localparam logic [IDX_W-1:0] IX_REST = 5'd3;
  localparam logic [IDX_W-1:0] IX_OPWD = 5'd4;
  localparam logic [IDX_W-1:0] IX_CMD  = 5'd5;
  localparam logic [IDX_W-1:0] IX_COND = 5'd7;
  localparam logic [IDX_W-1:0] IX_OPND = 5'd8;
  localparam logic [IDX_W-1:0] IX_RSEL = 5'd9;
  localparam logic [IDX_W-1:0] IX_IADR = 5'd10;
  localparam logic [IDX_W-1:0] IX_OADR = 5'd11;

  localparam logic [15:0] RSP_NULL = 16'h8000;
  localparam logic [15:0] RSP_XFER = 16'h4000;
  localparam logic [15:0] RSP_VIOL = 16'h2F00;

  typedef enum logic {PH_IDLE = 1'b0, PH_XFER = 1'b1} phase_t;

  typedef struct packed {
    logic sync_grp;   // in-operation group register
    logic oper;       // operand register specifically
    logic issue;      // command or condition register
    logic cmd_wr;     // command register write
    logic sr_open;    // save read or restore write
    logic ctrl_wr;    // control register write
    logic resp_rd;    // response register read
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic [IDX_W-1:0] idx, input logic rd);
    acc_kind_t k;
    k          = '0;
    k.sync_grp = (idx == IX_OPWD) || (idx == IX_OPND) || (idx == IX_RSEL) ||
                 (idx == IX_IADR) || (idx == IX_OADR);
    k.oper     = (idx == IX_OPND);
    k.issue    = (idx == IX_CMD) || (idx == IX_COND);
    k.cmd_wr   = (idx == IX_CMD) && !rd;
    k.sr_open  = ((idx == IX_SAVE) && rd) || ((idx == IX_REST) && !rd);
    k.ctrl_wr  = (idx == IX_CTRL) && !rd;
    k.resp_rd  = (idx == IX_RESP) && rd;
    return k;
  endfunction
endpackage

// File: rtl/cpg_bus_ack.sv
module cpg_bus_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  output logic ack,
  output logic take
);
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= cs;
  end

  assign ack  = ack_q;
  assign take = cs && !ack_q;
endmodule

// File: rtl/cpg_cmd_plan.sv
module cpg_cmd_plan #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic [DATA_W-1:0] cmd_word,
  output logic [CNT_W-1:0]  need
);
  generate
    if (CNT_W <= DATA_W) begin : g_slice
      assign need = cmd_word[CNT_W-1:0];
    end else begin : g_pad
      assign need = CNT_W'(cmd_word);
    end
  endgenerate
endmodule

// File: rtl/cpg_proto_fsm.sv
module cpg_proto_fsm
  import cpg_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  acc_kind_t        kind,
  input  logic             abort_bit,
  input  logic [CNT_W-1:0] need,
  output phase_t           phase,
  output logic [CNT_W-1:0] remain,
  output logic             viol,
  output logic             defer,
  output logic             sr_busy
);
  phase_t           phase_n;
  logic [CNT_W-1:0] remain_n;
  logic             viol_n, defer_n, sr_n;
  logic             bad;

  always_comb begin
    phase_n  = phase;
    remain_n = remain;
    viol_n   = viol;
    defer_n  = defer;
    sr_n     = sr_busy;
    bad      = (kind.sync_grp && phase == PH_IDLE) || (kind.issue && phase == PH_XFER);
    if (take) begin
      if (kind.issue) begin
        sr_n = 1'b0;
        if (defer || bad) begin
          viol_n   = 1'b1;
          defer_n  = 1'b0;
          phase_n  = PH_IDLE;
          remain_n = '0;
        end else if (kind.cmd_wr && need != '0) begin
          phase_n  = PH_XFER;
          remain_n = need;
        end else begin
          phase_n  = PH_IDLE;
          remain_n = '0;
        end
      end else if (kind.sync_grp) begin
        if (bad) begin
          if (sr_busy) defer_n = 1'b1;
          else         viol_n  = 1'b1;
        end else if (kind.oper) begin
          remain_n = remain - 1'b1;
          if (remain == CNT_W'(1)) phase_n = PH_IDLE;
        end
      end else if (kind.sr_open) begin
        sr_n = 1'b1;
      end else if (kind.ctrl_wr && abort_bit) begin
        viol_n   = 1'b0;
        defer_n  = 1'b0;
        sr_n     = 1'b0;
        phase_n  = PH_IDLE;
        remain_n = '0;
      end else if (kind.resp_rd && viol) begin
        viol_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      remain  <= '0;
      viol    <= 1'b0;
      defer   <= 1'b0;
      sr_busy <= 1'b0;
    end else begin
      phase   <= phase_n;
      remain  <= remain_n;
      viol    <= viol_n;
      defer   <= defer_n;
      sr_busy <= sr_n;
    end
  end
endmodule

// File: rtl/cpg_proto_guard.sv
module cpg_proto_guard
  import cpg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 3,
  parameter int ABORT_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rw,
  input  logic [4:0]        reg_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  localparam logic [DATA_W-1:0] W_NULL = DATA_W'(RSP_NULL);
  localparam logic [DATA_W-1:0] W_XFER = DATA_W'(RSP_XFER);
  localparam logic [DATA_W-1:0] W_VIOL = DATA_W'(RSP_VIOL);

  logic             take;
  acc_kind_t        kind;
  logic [CNT_W-1:0] need;
  phase_t           st_phase;
  logic [CNT_W-1:0] st_remain;
  logic             st_viol, st_defer, st_sr;
  logic [DATA_W-1:0] resp_word;
  logic [DATA_W-1:0] rdata_q;

  assign kind = classify(reg_idx, rw);

  cpg_bus_ack u_ack (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (cs),
    .ack  (ack),
    .take (take)
  );

  cpg_cmd_plan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_plan (
    .cmd_word(wdata),
    .need    (need)
  );

  cpg_proto_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .kind     (kind),
    .abort_bit(wdata[ABORT_BIT]),
    .need     (need),
    .phase    (st_phase),
    .remain   (st_remain),
    .viol     (st_viol),
    .defer    (st_defer),
    .sr_busy  (st_sr)
  );

  always_comb begin
    if (st_viol)                  resp_word = W_VIOL;
    else if (st_phase == PH_XFER) resp_word = W_XFER | DATA_W'(st_remain);
    else                          resp_word = W_NULL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (take) rdata_q <= kind.resp_rd ? resp_word : '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cpg_proto_guard_chk.sv
module cpg_proto_guard_chk #(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 3,
  parameter int ABORT_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rw,
  input logic [4:0]        reg_idx,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              ack,
  input logic              phase,
  input logic [CNT_W-1:0]  remain,
  input logic              viol,
  input logic              defer
);
  logic first;
  logic async_acc;
  assign first     = cs && !ack;
  assign async_acc = (reg_idx == 5'd0 && rw) || (reg_idx == 5'd2 && rw) ||
                     (reg_idx == 5'd3 && !rw) || (reg_idx == 5'd1 && !rw);

  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> ack); // R1
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !ack); // R1
  AST_VIOL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    first && rw && reg_idx == 5'd0 && viol |=> rdata == DATA_W'(16'h2F00) && !viol); // R4
  AST_NO_ASYNC_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    first && async_acc && !viol && !defer |=> !viol && !defer); // R6
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    first && !rw && reg_idx == 5'd1 && wdata[ABORT_BIT] |=> !viol && !defer && !phase); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> remain == '0); // R3
endmodule

bind cpg_proto_guard cpg_proto_guard_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ABORT_BIT(ABORT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .reg_idx(reg_idx), .wdata(wdata),
  .rdata(rdata), .ack(ack), .phase(st_phase), .remain(st_remain),
  .viol(st_viol), .defer(st_defer)
);

// File: tb/cpg_proto_guard_bench.sv
module cpg_proto_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        rw = 1'b1;
  logic [4:0]  reg_idx = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ack;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string cur_req = "R11";

  // behavioural reference state
  int m_ack = 0, m_rdata = 0, m_xfer = 0, m_left = 0;
  int m_viol = 0, m_hold = 0, m_sr = 0;
  int a_now = 0, bad = 0, ix = 0, rd = 0;

  always #10 clk = ~clk;  // 50 MHz

  cpg_proto_guard u_cpg_proto_guard (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .ack(ack)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack = 0; m_rdata = 0; m_xfer = 0; m_left = 0; m_viol = 0; m_hold = 0; m_sr = 0;
    end else begin
      a_now = (cs && !m_ack) ? 1 : 0;
      m_ack = cs ? 1 : 0;
      if (a_now != 0) begin
        ix = int'(reg_idx); rd = int'(rw);
        m_rdata = 0;
        if (ix == 0 && rd == 1)
          m_rdata = (m_viol != 0) ? 'h2F00 : (m_xfer != 0) ? ('h4000 + m_left) : 'h8000;
        bad = ((m_xfer == 0) && (ix == 4 || (ix >= 8 && ix <= 11))) ||
              ((m_xfer != 0) && (ix == 5 || ix == 7)) ? 1 : 0;
        if (ix == 5 || ix == 7) begin
          m_sr = 0;
          if (m_hold != 0 || bad != 0) begin
            m_viol = 1; m_hold = 0; m_xfer = 0; m_left = 0;
          end else if (ix == 5 && rd == 0 && (wdata & 7) != 0) begin
            m_xfer = 1; m_left = int'(wdata & 7);
          end else begin
            m_xfer = 0; m_left = 0;
          end
        end else if (ix == 4 || (ix >= 8 && ix <= 11)) begin
          if (bad != 0) begin
            if (m_sr != 0) m_hold = 1; else m_viol = 1;
          end else if (ix == 8) begin
            m_left = m_left - 1;
            if (m_left == 0) m_xfer = 0;
          end
        end else if ((ix == 2 && rd == 1) || (ix == 3 && rd == 0)) begin
          m_sr = 1;
        end else if (ix == 1 && rd == 0 && wdata[1]) begin
          m_viol = 0; m_hold = 0; m_sr = 0; m_xfer = 0; m_left = 0;
        end else if (ix == 0 && rd == 1) begin
          m_viol = 0;
        end
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (ack !== (m_ack != 0) || rdata !== 16'(m_rdata)) begin
        mismatched++;
        $display("FAIL %s: ack=%0b rdata=%h expected ack=%0b rdata=%h",
                 cur_req, ack, rdata, m_ack, 16'(m_rdata));
      end
    end
  end

  task automatic check_resp(input logic [15:0] exp, input string tag);
    cs = 1; rw = 1; reg_idx = 5'd0; wdata = '0;
    @(negedge clk);
    cs = 0;
    @(negedge clk);
    compared++;
    if (rdata !== exp) begin
      mismatched++;
      $display("FAIL %s: response rdata=%h expected %h", tag, rdata, exp);
    end
  endtask

  task automatic acc(input logic r, input logic [4:0] x, input logic [15:0] d, input int hold);
    cs = 1; rw = r; reg_idx = x; wdata = d;
    repeat (hold) @(negedge clk);
    cs = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    compared++;
    if (ack !== 1'b0 || rdata !== 16'h0) begin
      mismatched++;
      $display("FAIL R11: reset ack=%0b rdata=%h expected ack=0 rdata=0000", ack, rdata);
    end
    rst_n = 1;
    @(negedge clk);
    check_resp(16'h8000, "R11");

    cur_req = "R2";
    check_resp(16'h8000, "R2");
    acc(0, 5'd6, 16'h1234, 1);  // write loads zero read data
    compared++;
    if (rdata !== 16'h0) begin
      mismatched++;
      $display("FAIL R2: rdata=%h expected 0000", rdata);
    end

    cur_req = "R10";
    acc(0, 5'd7, 16'h0003, 1);
    acc(1, 5'd7, 16'h0000, 1);
    acc(0, 5'd13, 16'hFFFF, 1);
    check_resp(16'h8000, "R10");

    cur_req = "R3";
    acc(0, 5'd5, 16'h0003, 1);
    check_resp(16'h4003, "R3");
    acc(0, 5'd8, 16'h00AA, 1);
    check_resp(16'h4002, "R3");
    acc(1, 5'd8, 16'h0000, 1);
    acc(0, 5'd8, 16'h0055, 1);
    check_resp(16'h8000, "R3");
    acc(0, 5'd5, 16'h0000, 1);
    check_resp(16'h8000, "R3");
    acc(0, 5'd5, 16'h0007, 1);
    check_resp(16'h4007, "R3");
    for (int i = 0; i < 6; i++) acc(0, 5'd8, 16'(i), 1);
    check_resp(16'h4001, "R3");
    acc(0, 5'd8, 16'h0007, 1);
    check_resp(16'h8000, "R3");

    cur_req = "R5";
    acc(0, 5'd5, 16'h0002, 1);
    acc(0, 5'd4, 16'hF000, 1);
    acc(0, 5'd9, 16'h0011, 1);
    acc(0, 5'd10, 16'h2000, 1);
    acc(1, 5'd11, 16'h0000, 1);
    check_resp(16'h4002, "R5");
    acc(0, 5'd8, 16'h0001, 1);
    acc(0, 5'd8, 16'h0002, 1);
    check_resp(16'h8000, "R5");

    cur_req = "R4";
    acc(0, 5'd8, 16'h0001, 1);
    check_resp(16'h2F00, "R4");
    check_resp(16'h8000, "R4");
    acc(1, 5'd10, 16'h0000, 1);
    check_resp(16'h2F00, "R4");

    cur_req = "R6";
    acc(0, 5'd1, 16'h0001, 1);
    check_resp(16'h8000, "R6");
    acc(0, 5'd5, 16'h0002, 1);
    acc(0, 5'd1, 16'h0000, 1);
    check_resp(16'h4002, "R6");
    acc(0, 5'd3, 16'h0000, 1);
    acc(1, 5'd2, 16'h0000, 1);
    check_resp(16'h4002, "R6");
    acc(0, 5'd8, 16'h0000, 1);
    acc(0, 5'd8, 16'h0000, 1);
    check_resp(16'h8000, "R6");

    cur_req = "R7";
    acc(1, 5'd2, 16'h0000, 1);
    acc(0, 5'd8, 16'h0001, 1);
    check_resp(16'h8000, "R7");
    acc(0, 5'd5, 16'h0002, 1);
    check_resp(16'h2F00, "R7");
    check_resp(16'h8000, "R7");
    acc(0, 5'd3, 16'h0000, 1);
    acc(0, 5'd4, 16'h0000, 1);
    acc(0, 5'd7, 16'h0000, 1);
    check_resp(16'h2F00, "R7");

    cur_req = "R8";
    acc(0, 5'd5, 16'h0003, 1);
    acc(0, 5'd5, 16'h0001, 1);
    check_resp(16'h2F00, "R8");
    check_resp(16'h8000, "R8");
    acc(0, 5'd5, 16'h0002, 1);
    acc(1, 5'd7, 16'h0000, 1);
    check_resp(16'h2F00, "R8");

    cur_req = "R9";
    acc(0, 5'd4, 16'h0000, 1);
    acc(0, 5'd1, 16'h0002, 1);
    check_resp(16'h8000, "R9");
    acc(0, 5'd5, 16'h0003, 1);
    acc(0, 5'd1, 16'h0002, 1);
    check_resp(16'h8000, "R9");
    acc(0, 5'd3, 16'h0000, 1);
    acc(0, 5'd8, 16'h0000, 1);
    acc(0, 5'd1, 16'h0002, 1);
    acc(0, 5'd5, 16'h0001, 1);
    check_resp(16'h4001, "R9");
    acc(0, 5'd8, 16'h0000, 1);

    cur_req = "R1";
    acc(0, 5'd5, 16'h0002, 1);
    acc(0, 5'd8, 16'h0000, 4);
    check_resp(16'h4001, "R1");
    acc(0, 5'd4, 16'h0000, 3);  // legal in transfer, acknowledged
    acc(0, 5'd8, 16'h0000, 1);
    acc(0, 5'd8, 16'h0000, 3);  // illegal in idle, still acknowledged
    check_resp(16'h2F00, "R1");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule